// File: doc/BRIEF.md
# Page-Oriented Two-Wire EEPROM Master

This block is a bus-master-only controller for a two-wire serial EEPROM bus. A CPU pushes bytes into a 35-entry byte queue: first a header (the device ID byte, then zero, one or two address bytes as the target part needs), then, for a write, the payload. A one-cycle write launch sends the whole page in one transaction: start, header, data and stop, with the slave's acknowledge checked after every byte. A one-cycle read launch sends the header as an address-setting write, then a repeated start and the device ID with the read bit set, and clocks in a programmed number of bytes. Each byte is handed to the CPU on a one-cycle strobe.

The transaction sequencer has eight states. IDLE leaves on a launch to OPEN, which issues a start condition. OPEN goes to HEADER. HEADER sends the header bytes one at a time and then branches: to REOPEN for a read, to PAYLOAD for a write with data, or to CLOSE for a write with no data. PAYLOAD loops until the page count runs out, then goes to CLOSE. REOPEN issues the repeated start and goes to READID. READID sends the ID with the read bit set and goes to FETCH. FETCH loops over the read bytes, then goes to CLOSE. CLOSE issues the stop condition and returns to IDLE. A refused byte in HEADER, PAYLOAD or READID goes straight to CLOSE. Below the sequencer, a bit engine (states REST, BEGIN, END, SHIFT) splits each command into quarter-periods of SCL. A divider sets the length of those quarter-periods.

Both bus lines are open-drain. Each output, when 1, pulls its line low. The SDA line is read back through an input.

Top module: `i2c_page_master`

## Requirements
- R1: After reset, neither bus line is pulled low, busy, done and nack_err are 0, and fifo_level is 0.
- R2: While idle, each cycle with fifo_push set stores one byte. fifo_level counts the stored bytes up to 35. A push into a full queue is dropped.
- R3: A write launch (wr_go) sends a start, then the first queued byte with bit 0 forced to 0, then addr_bytes address bytes (0, 1 or 2; the value 3 acts as 2), then the data bytes, then a stop. The slave stores the data from the given address onward.
- R4: page_sel limits a write to 8 (code 0), 16 (code 1) or 32 (codes 2 and 3) data bytes. Queued bytes beyond that limit are not sent. The queue is empty (fifo_level 0) after every transaction.
- R5: A read launch (rd_go, used when wr_go is low) sends the ID and address bytes as a write, then a repeated start, then the ID with bit 0 set to 1. It then receives rd_len+1 bytes (1 to 32) and presents each one on rx_data, with a one-cycle rx_valid, in bus order.
- R6: During a read, the master acknowledges (SDA low) every received byte except the last. It leaves SDA high on the last byte.
- R7: If the slave leaves SDA high in the acknowledge slot of any header, ID or write-data byte, no further byte is sent, a stop follows, and nack_err and done are 1 at the end.
- R8: busy is 1 from the cycle after a launch until the stop condition has completed. Then done is 1 and stays 1 until the next launch. Both bus lines are released at the end.
- R9: Within a byte, SCL has a period of 4*(clk_div+1) clock cycles.
- R10: SDA changes only while SCL is low, except for the start and stop conditions. A write therefore shows exactly one start and one stop on the bus. A read shows two starts and one stop.
- R11: While busy, fifo_push, wr_go and rd_go have no effect. No byte is added, and no second transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_push | input | 1 | Store fifo_byte in the queue |
| fifo_byte | input | 8 | Header or payload byte |
| wr_go | input | 1 | Launch a page write |
| rd_go | input | 1 | Launch a read |
| addr_bytes | input | 2 | Number of address bytes in the header |
| page_sel | input | 2 | Page size code: 0=8, 1=16, otherwise 32 |
| rd_len | input | 5 | Number of read bytes minus one |
| clk_div | input | 16 | Quarter-period of SCL minus one, in clock cycles |
| scl_low | output | 1 | Pull SCL low |
| sda_low | output | 1 | Pull SDA low |
| sda_in | input | 1 | Level sensed on SDA |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Last transaction finished |
| nack_err | output | 1 | Last transaction was refused by the slave |
| fifo_level | output | 6 | Bytes currently queued |
| rx_valid | output | 1 | rx_data holds a received byte |
| rx_data | output | 8 | Received byte |

## Verification
A sequencer stuck in a wrong state shows up on the bus within one byte time. Possible signs are a missing or extra start or stop, a byte count that does not match the page or read length, or busy that never falls. A miscounted header or page shows up as data stored at the wrong address or past the page limit in the bench's slave model. It also shows as fifo_level not at zero once done rises. A bit-engine phase error moves SDA while SCL is high, which the slave model sees at once as a spurious start or stop, or it changes the measured SCL period. A wrong acknowledge decision appears in the slave's count of master acknowledges, and in nack_err when the transaction ends.

// File: rtl/i2cpm_pkg.sv
package i2cpm_pkg;
    typedef enum logic [1:0] {CMD_START, CMD_STOP, CMD_WRITE, CMD_READ} cmd_e;
    typedef enum logic [1:0] {E_REST, E_BEGIN, E_END, E_SHIFT} eng_e;
    typedef enum logic [2:0] {
        T_IDLE, T_OPEN, T_HEADER, T_PAYLOAD, T_REOPEN, T_READID, T_FETCH, T_CLOSE
    } txn_e;

    function automatic logic [5:0] page_bytes(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 6'd8;
            2'd1:    return 6'd16;
            default: return 6'd32;
        endcase
    endfunction
endpackage

// File: rtl/i2cpm_fifo.sv
module i2cpm_fifo #(
    parameter int DEPTH = 35,
    parameter int W     = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    input  logic          clear,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rp, wp;
    logic          full, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full && !clear;
    assign do_pop  = pop && (count != '0) && !clear;
    assign head    = mem[rp];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp    <= '0;
            wp    <= '0;
            count <= '0;
        end else if (clear) begin
            rp    <= '0;
            wp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_full_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clear) |=> count == CW'(DEPTH));
endmodule

// File: rtl/i2cpm_tick.sv
module i2cpm_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (!en) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cpm_bitseq.sv
module i2cpm_bitseq
    import i2cpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       go,
    input  cmd_e       cmd,
    input  logic [7:0] tx,
    input  logic       ack_bit,
    input  logic       sda_in,
    output logic       done,
    output logic       nack,
    output logic [7:0] rx,
    output logic       scl_low,
    output logic       sda_low
);
    eng_e       st;
    logic [1:0] ph;
    logic [3:0] bitn;
    logic [7:0] txr;
    logic       rd, ackr;
    logic       scl_rel, sda_rel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= E_REST;
            ph   <= '0;
            bitn <= '0;
            txr  <= '0;
            rd   <= 1'b0;
            ackr <= 1'b1;
        end else if (st == E_REST) begin
            if (go) begin
                ph   <= '0;
                bitn <= '0;
                txr  <= tx;
                rd   <= (cmd == CMD_READ);
                ackr <= ack_bit;
                unique case (cmd)
                    CMD_START: st <= E_BEGIN;
                    CMD_STOP:  st <= E_END;
                    default:   st <= E_SHIFT;
                endcase
            end
        end else if (tick) begin
            ph <= ph + 1'b1;
            if (ph == 2'd3) begin
                if (st != E_SHIFT || bitn == 4'd8) st <= E_REST;
                else bitn <= bitn + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            nack <= 1'b0;
            rx   <= '0;
        end else begin
            done <= (st != E_REST) && tick && (ph == 2'd3) && (st != E_SHIFT || bitn == 4'd8);
            if (st == E_SHIFT && tick && ph == 2'd2) begin
                if (bitn < 4'd8) rx   <= {rx[6:0], sda_in};
                else             nack <= sda_in;
            end
        end
    end

    always_comb begin
        scl_rel = 1'b1;
        sda_rel = 1'b1;
        unique case (st)
            E_BEGIN: begin
                scl_rel = (ph == 2'd1) || (ph == 2'd2);
                sda_rel = (ph < 2'd2);
            end
            E_END: begin
                scl_rel = (ph != 2'd0);
                sda_rel = (ph >= 2'd2);
            end
            E_SHIFT: begin
                scl_rel = (ph == 2'd1) || (ph == 2'd2);
                if (bitn == 4'd8) sda_rel = rd ? ackr : 1'b1;
                else              sda_rel = rd ? 1'b1 : txr[~bitn[2:0]];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_low <= 1'b0;
            sda_low <= 1'b0;
        end else if (st != E_REST) begin
            scl_low <= !scl_rel;
            sda_low <= !sda_rel;
        end
    end

    assert_sda_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_low && !$past(scl_low) && st == E_SHIFT && $past(st) == E_SHIFT)
        |-> sda_low == $past(sda_low));
endmodule

// File: rtl/i2c_page_master.sv
module i2c_page_master
    import i2cpm_pkg::*;
#(
    parameter int FIFO_DEPTH = 35,
    parameter int DIV_W      = 16,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_push,
    input  logic [7:0]       fifo_byte,
    input  logic             wr_go,
    input  logic             rd_go,
    input  logic [1:0]       addr_bytes,
    input  logic [1:0]       page_sel,
    input  logic [4:0]       rd_len,
    input  logic [DIV_W-1:0] clk_div,
    output logic             scl_low,
    output logic             sda_low,
    input  logic             sda_in,
    output logic             busy,
    output logic             done,
    output logic             nack_err,
    output logic [LVL_W-1:0] fifo_level,
    output logic             rx_valid,
    output logic [7:0]       rx_data
);
    txn_e       st, st_nx;
    logic       pend, is_rd, first;
    logic [1:0] hdr_left, hdr_n;
    logic [5:0] data_left, wlen, cap;
    logic [7:0] id_r, head, e_tx, e_rx;
    logic       launch, e_go, e_ack, e_done, e_nack, tick, pop, clr;
    cmd_e       e_cmd;
    logic [LVL_W-1:0] avail;

    assign launch = (st == T_IDLE) && (wr_go || rd_go);
    assign hdr_n  = (addr_bytes == 2'd3) ? 2'd3 : addr_bytes + 2'd1;
    assign avail  = (fifo_level > LVL_W'(hdr_n)) ? fifo_level - LVL_W'(hdr_n) : '0;
    assign cap    = page_bytes(page_sel);
    assign wlen   = (avail > LVL_W'(cap)) ? cap : 6'(avail);
    assign e_go   = (st != T_IDLE) && !pend;
    assign pop    = e_go && (st == T_HEADER || st == T_PAYLOAD);
    assign clr    = (st == T_CLOSE) && e_done;

    always_comb begin
        e_cmd = CMD_WRITE;
        e_tx  = head;
        e_ack = 1'b1;
        unique case (st)
            T_OPEN, T_REOPEN: e_cmd = CMD_START;
            T_CLOSE:          e_cmd = CMD_STOP;
            T_HEADER:         e_tx  = first ? {head[7:1], 1'b0} : head;
            T_READID:         e_tx  = {id_r[7:1], 1'b1};
            T_FETCH: begin
                e_cmd = CMD_READ;
                e_ack = (data_left == 6'd1);
            end
            default: ;
        endcase
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            T_IDLE:    if (launch) st_nx = T_OPEN;
            T_OPEN:    if (e_done) st_nx = T_HEADER;
            T_HEADER:  if (e_done) begin
                if (e_nack)                st_nx = T_CLOSE;
                else if (hdr_left == 2'd1) st_nx = is_rd ? T_REOPEN :
                                                  (data_left == '0) ? T_CLOSE : T_PAYLOAD;
            end
            T_PAYLOAD: if (e_done && (e_nack || data_left == 6'd1)) st_nx = T_CLOSE;
            T_REOPEN:  if (e_done) st_nx = T_READID;
            T_READID:  if (e_done) st_nx = e_nack ? T_CLOSE : T_FETCH;
            T_FETCH:   if (e_done && data_left == 6'd1) st_nx = T_CLOSE;
            T_CLOSE:   if (e_done) st_nx = T_IDLE;
            default:   st_nx = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= T_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0; is_rd <= 1'b0; first <= 1'b0;
            hdr_left <= '0; data_left <= '0; id_r <= '0;
            busy <= 1'b0; done <= 1'b0; nack_err <= 1'b0;
            rx_valid <= 1'b0; rx_data <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (e_go)   pend <= 1'b1;
            if (e_done) pend <= 1'b0;
            if (launch) begin
                busy      <= 1'b1;
                done      <= 1'b0;
                nack_err  <= 1'b0;
                is_rd     <= !wr_go;
                first     <= 1'b1;
                hdr_left  <= hdr_n;
                data_left <= wr_go ? wlen : 6'(rd_len) + 6'd1;
            end
            if (pop && first) begin
                id_r  <= head;
                first <= 1'b0;
            end
            if (e_done) begin
                unique case (st)
                    T_HEADER:  hdr_left  <= hdr_left - 2'd1;
                    T_PAYLOAD: data_left <= data_left - 6'd1;
                    T_FETCH: begin
                        data_left <= data_left - 6'd1;
                        rx_valid  <= 1'b1;
                        rx_data   <= e_rx;
                    end
                    T_CLOSE: begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                    default: ;
                endcase
                if ((st == T_HEADER || st == T_PAYLOAD || st == T_READID) && e_nack)
                    nack_err <= 1'b1;
            end
        end
    end

    i2cpm_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(fifo_push && !busy), .din(fifo_byte),
        .pop(pop), .clear(clr), .head(head), .count(fifo_level)
    );

    i2cpm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(busy), .div(clk_div), .tick(tick)
    );

    i2cpm_bitseq u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .go(e_go), .cmd(e_cmd), .tx(e_tx),
        .ack_bit(e_ack), .sda_in(sda_in), .done(e_done), .nack(e_nack), .rx(e_rx),
        .scl_low(scl_low), .sda_low(sda_low)
    );

    assert_done_excl_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    assert_err_ends_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_err && !busy) |-> done);
    assert_rx_only_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> is_rd);
    assert_no_push_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> fifo_level <= $past(fifo_level));
endmodule

// File: tb/tb_i2c_page_master.sv
`timescale 1ns/1ps
module tb_i2c_page_master;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_push = 1'b0, wr_go = 1'b0, rd_go = 1'b0;
    logic [7:0] fifo_byte = '0;
    logic [1:0] addr_bytes = 2'd1, page_sel = 2'd0;
    logic [4:0] rd_len = '0;
    logic [15:0] clk_div = 16'd1;
    logic scl_low, sda_low, busy, done, nack_err, rx_valid;
    logic [5:0] fifo_level;
    logic [7:0] rx_data;
    logic s_drive = 1'b0;
    wire scl_line = !scl_low;
    wire sda_line = !sda_low && !s_drive;

    int n_tests = 0, n_fail = 0;

    always #4 clk = !clk;

    i2c_page_master dut (
        .clk(clk), .rst_n(rst_n), .fifo_push(fifo_push), .fifo_byte(fifo_byte),
        .wr_go(wr_go), .rd_go(rd_go), .addr_bytes(addr_bytes), .page_sel(page_sel),
        .rd_len(rd_len), .clk_div(clk_div), .scl_low(scl_low), .sda_low(sda_low),
        .sda_in(sda_line), .busy(busy), .done(done), .nack_err(nack_err),
        .fifo_level(fifo_level), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    // slave EEPROM model
    logic [7:0] mem [256];
    logic [7:0] shreg, txb, s_hi;
    int bitc, byte_i, ptr, s_abytes = 1, s_nack_at = -1;
    int s_starts, s_stops, s_wcnt, s_macks, s_mnacks;
    bit active = 0, skip, sending, go_send, mack;

    always @(negedge sda_line) if (scl_line === 1'b1) begin
        active = 1; skip = 1; bitc = 0; byte_i = 0;
        sending = 0; go_send = 0; s_drive = 0; s_starts++;
    end
    always @(posedge sda_line) if (scl_line === 1'b1 && active) begin
        active = 0; s_drive = 0; s_stops++;
    end
    always @(posedge scl_line) if (active) begin
        if (bitc < 8 && !sending) shreg = {shreg[6:0], sda_line};
        else if (bitc == 8 && sending) mack = sda_line;
    end
    always @(negedge scl_line) if (active) begin
        if (skip) skip = 0;
        else if (bitc < 7) begin
            bitc++;
            if (sending) s_drive = !txb[7-bitc];
        end else if (bitc == 7) begin
            bit ack;
            bitc = 8;
            if (sending) s_drive = 0;
            else begin
                if (byte_i == 0) begin
                    ack = (shreg[7:1] == 7'h50) && (s_nack_at != 0);
                    if (shreg[0]) go_send = ack;
                end else begin
                    ack = (s_nack_at != byte_i);
                    if (ack) begin
                        if (byte_i <= s_abytes) begin
                            if (s_abytes == 2 && byte_i == 1) s_hi = shreg;
                            else ptr = int'(shreg);
                        end else begin
                            mem[ptr] = shreg; ptr = (ptr + 1) % 256; s_wcnt++;
                        end
                    end
                end
                byte_i++;
                s_drive = ack;
            end
        end else begin
            bitc = 0;
            if (sending) begin
                if (!mack) begin
                    s_macks++; ptr = (ptr + 1) % 256; txb = mem[ptr]; s_drive = !txb[7];
                end else begin
                    s_mnacks++; sending = 0; s_drive = 0;
                end
            end else begin
                s_drive = 0;
                if (go_send) begin
                    go_send = 0; sending = 1; txb = mem[ptr]; s_drive = !txb[7];
                end
            end
        end
    end

    // SCL period probe
    int pos_n; realtime t_a, t_b;
    always @(posedge scl_line) begin
        pos_n++;
        if (pos_n == 3) t_a = $realtime;
        if (pos_n == 4) t_b = $realtime;
    end

    // received bytes
    logic [7:0] rxq [32];
    int rx_n;
    always @(posedge clk) if (rx_valid && rx_n < 32) begin rxq[rx_n] <= rx_data; rx_n <= rx_n + 1; end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic s_clear();
        s_starts = 0; s_stops = 0; s_wcnt = 0; s_macks = 0; s_mnacks = 0;
        s_nack_at = -1; pos_n = 0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); fifo_push = 1'b1; fifo_byte = b;
        @(negedge clk); fifo_push = 1'b0;
    endtask

    task automatic go(input bit wr);
        @(negedge clk); wr_go = wr; rd_go = !wr;
        @(negedge clk); wr_go = 1'b0; rd_go = 1'b0;
    endtask

    task automatic wait_idle();
        int lim = 0;
        while (busy && lim < 30000) begin @(negedge clk); lim++; end
        check(!busy, "R8 busy stuck", int'(busy), 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check(scl_low == 0 && sda_low == 0, "R1 lines released", int'({scl_low, sda_low}), 0);
        check(!busy && !done && !nack_err, "R1 flags clear", int'({busy, done, nack_err}), 0);
        check(fifo_level == 0, "R1 fifo empty", int'(fifo_level), 0);
    endtask

    task automatic t_full_page32();
        s_clear(); s_abytes = 1; addr_bytes = 2'd1; page_sel = 2'd2;
        push(8'hA1); push(8'h00);
        for (int i = 0; i < 35; i++) push(8'(8'h80 + i));
        check(fifo_level == 35, "R2 fifo caps at 35", int'(fifo_level), 35);
        go(1'b1);
        check(busy == 1, "R8 busy after launch", int'(busy), 1);
        wait_idle();
        check(s_wcnt == 32, "R4 page 32 count", s_wcnt, 32);
        check(mem[31] == 8'h9F && mem[0] == 8'h80, "R3 data stored", int'(mem[31]), 8'h9F);
        check(mem[32] == 8'hFF, "R4 beyond page untouched", int'(mem[32]), 8'hFF);
        check(fifo_level == 0, "R4 fifo emptied", int'(fifo_level), 0);
        check(done && !nack_err, "R8 done set", int'({done, nack_err}), 2);
        check(scl_low == 0 && sda_low == 0, "R8 lines released", int'({scl_low, sda_low}), 0);
    endtask

    task automatic t_page8();
        s_clear(); page_sel = 2'd0;
        push(8'hA0); push(8'h40);
        for (int i = 0; i < 10; i++) push(8'(8'h10 + i));
        go(1'b1);
        check(!done, "R8 done cleared on launch", int'(done), 0);
        wait_idle();
        check(s_wcnt == 8, "R4 page 8 count", s_wcnt, 8);
        check(mem[8'h47] == 8'h17, "R3 last byte of page", int'(mem[8'h47]), 8'h17);
        check(mem[8'h48] == 8'hFF, "R4 extra bytes dropped", int'(mem[8'h48]), 8'hFF);
        check(s_starts == 1 && s_stops == 1, "R10 one start one stop", s_starts*10 + s_stops, 11);
        check(fifo_level == 0, "R4 leftovers flushed", int'(fifo_level), 0);
    endtask

    task automatic t_two_addr();
        s_clear(); s_abytes = 2; addr_bytes = 2'd2; page_sel = 2'd1;
        push(8'hA0); push(8'h3C); push(8'h60);
        for (int i = 0; i < 16; i++) push(8'(8'hC0 + i));
        go(1'b1); wait_idle();
        check(s_hi == 8'h3C, "R3 high address byte", int'(s_hi), 8'h3C);
        check(s_wcnt == 16 && mem[8'h6F] == 8'hCF, "R4 page 16", s_wcnt, 16);
        s_abytes = 1; addr_bytes = 2'd1;
    endtask

    task automatic t_read();
        s_clear(); rx_n = 0; rd_len = 5'd3; clk_div = 16'd4;
        push(8'hA0); push(8'h40);
        go(1'b0); wait_idle();
        check(rx_n == 4, "R5 read byte count", rx_n, 4);
        for (int i = 0; i < 4; i++)
            check(rxq[i] == 8'(8'h10 + i), "R5 read data", int'(rxq[i]), 8'h10 + i);
        check(s_macks == 3 && s_mnacks == 1, "R6 ack pattern", s_macks*10 + s_mnacks, 31);
        check(s_starts == 2 && s_stops == 1, "R10 read starts", s_starts*10 + s_stops, 21);
        check((t_b - t_a) == 8.0*20, "R9 scl period div 4", int'(t_b - t_a), 160);
        clk_div = 16'd1;
    endtask

    task automatic t_period_fast();
        s_clear(); rx_n = 0; rd_len = 5'd0;
        push(8'hA0); push(8'h00);
        go(1'b0); wait_idle();
        check((t_b - t_a) == 8.0*8, "R9 scl period div 1", int'(t_b - t_a), 64);
        check(rx_n == 1 && rxq[0] == 8'h80, "R5 single byte read", int'(rxq[0]), 8'h80);
        check(s_macks == 0 && s_mnacks == 1, "R6 lone byte nacked", s_macks*10 + s_mnacks, 1);
    endtask

    task automatic t_nack_id();
        s_clear(); page_sel = 2'd0;
        push(8'hB0); push(8'h50); push(8'h01); push(8'h02);
        go(1'b1); wait_idle();
        check(nack_err && done, "R7 id refused flags", int'({nack_err, done}), 3);
        check(s_wcnt == 0 && mem[8'h50] == 8'hFF, "R7 nothing written", s_wcnt, 0);
        check(s_stops == 1, "R7 stop after refusal", s_stops, 1);
        check(fifo_level == 0, "R4 flush after refusal", int'(fifo_level), 0);
    endtask

    task automatic t_nack_data();
        s_clear(); s_nack_at = 2;
        push(8'hA0); push(8'h90); push(8'h11); push(8'h22); push(8'h33);
        go(1'b1); wait_idle();
        check(nack_err, "R7 data refused", int'(nack_err), 1);
        check(mem[8'h91] == 8'hFF && s_wcnt == 0, "R7 no byte after refusal", int'(mem[8'h91]), 8'hFF);
    endtask

    task automatic t_busy_ignore();
        s_clear();
        push(8'hA0); push(8'hA0); push(8'h5A);
        go(1'b1);
        repeat (10) @(negedge clk);
        fifo_push = 1'b1; fifo_byte = 8'h77; rd_go = 1'b1; wr_go = 1'b1;
        @(negedge clk); fifo_push = 1'b0; rd_go = 1'b0; wr_go = 1'b0;
        check(fifo_level <= 2, "R11 push ignored while busy", int'(fifo_level), 2);
        wait_idle();
        repeat (100) @(negedge clk);
        check(!busy && s_starts == 1, "R11 no second transaction", s_starts, 1);
        check(mem[8'hA0] == 8'h5A && mem[8'hA1] == 8'hFF, "R11 single data byte", int'(mem[8'hA1]), 8'hFF);
        check(fifo_level == 0, "R11 queue empty afterwards", int'(fifo_level), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        s_clear(); rx_n = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_full_page32();
        t_page8();
        t_two_addr();
        t_read();
        t_period_fast();
        t_nack_id();
        t_nack_data();
        t_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 190000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule